// File: doc/BRIEF.md
# Shift-and-Add Horner Multiplier

This block multiplies a signed 16-bit operand by an unsigned 16-bit coefficient without a hardware multiplier. It uses only additions and shifts of a running partial sum. Each clock it visits one set bit of the coefficient. The shift applied to the partial sum is the gap between that bit and the next set bit to visit, so zero bits cost no cycles.

A mode input picks the interpretation.

- **Fractional mode:** the operand is Q15 and the coefficient is an unsigned Q15 fraction below one. The walk starts at the lowest set bit and moves upward, shifting the partial sum right. Two guard bits below the Q15 point soften the truncation.
- **Integer mode:** both values are integers. The walk starts at the highest set bit and moves downward, shifting the partial sum left. The block raises a flag when the product does not fit the signed output width.

A caller raises `start` for one cycle with the operands. The caller then waits for the one-cycle `done` pulse and reads `result` and `ovf`, which hold until the next completion.

Top module: `horner_mul`

## Requirements
- R1: After reset, `done`, `ovf` and `result` are all zero.
- R2: For the effective coefficient E, `done` is high for exactly one cycle, popcount(E)+1 cycles after the cycle in which `start` was sampled. The block retires one set bit per clock. In fractional mode E is `m_in` with bit 15 cleared. In integer mode E is `m_in`.
- R3: When E is zero, `done` rises in the cycle after `start` with `result` = 0 and `ovf` = 0.
- R4: Fractional mode (`int_mode` = 0) computes `result` as follows:
  - Start with A = 0.
  - For each set bit k of E, from bit 0 upward, let n be the next set bit above k, or 15 if there is none. Set A = floor((A + 4·x) / 2^(n−k)).
  - The output is floor(A/4), taken to 16 bits.
- R5: In fractional mode, with P = x·E, the product in units of 2^-30, `result`·2^15 ≤ P and P − `result`·2^15 < 1.5·2^15. The result never lies above the exact product and is less than 1.5 LSB below it.
- R6: Fractional mode ignores bit 15 of `m_in`. It changes neither `result` nor the latency.
- R7: Integer mode (`int_mode` = 1) returns the low 16 bits of x·`m_in`, with x signed and `m_in` unsigned.
- R8: In integer mode, `ovf` is 1 exactly when x·`m_in` lies outside [−32768, 32767]. In fractional mode, `ovf` is always 0.
- R9: While an operation is in flight, `start` and all operand inputs are ignored. `result` and `ovf` hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| int_mode | input | 1 | 1 = integer mode, 0 = fractional Q15 mode |
| x_in | input | 16 | Signed operand |
| m_in | input | 16 | Unsigned coefficient |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Product, held until the next completion |
| ovf | output | 1 | Integer-mode out-of-range flag |

## Verification
The in-design properties assume that `start` is only meaningful while the block is idle. They also assume that the caller reads `result` only with or after `done`, since `result` is not defined as changing at any other time.

The stimulus sweeps both modes over a spread of signed operands and pseudo-random coefficients. It adds all single-bit coefficients and the zero and top-bit edges. Every operation waits for `done` before the next `start`. Some operations deliberately hold `start` high with scrambled operands throughout the busy window, to show that such traffic has no effect.

// File: rtl/horner_mul.sv
module horner_mul #(
  parameter int W = 16,
  parameter int G = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         int_mode,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] m_in,
  output logic         done,
  output logic [W-1:0] result,
  output logic         ovf
);
  localparam int AW = 2 * W;
  localparam int IW = $clog2(W) + 1;

  function automatic logic [IW-1:0] lo_idx(input logic [W-1:0] v);
    logic [IW-1:0] r;
    r = IW'(W - 1);
    for (int i = W - 1; i >= 0; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  function automatic logic [IW-1:0] hi_idx(input logic [W-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) if (v[i]) r = IW'(i);
    return r;
  endfunction

  logic                 busy, mode_q;
  logic signed [W-1:0]  x_q;
  logic [W-1:0]         rem;
  logic [IW-1:0]        prev;
  logic signed [AW-1:0] acc;

  logic [W-1:0]         m_eff, rest;
  logic [IW-1:0]        cur, nxt;
  logic signed [AW-1:0] xs, fsum, facc, fres, isum, ifin, acc_nxt;
  logic                 last, ifin_ovf;

  assign m_eff    = int_mode ? m_in : {1'b0, m_in[W-2:0]};
  assign cur      = mode_q ? hi_idx(rem) : lo_idx(rem);
  assign rest     = rem & ~(W'(1) << cur);
  assign last     = (rest == '0);
  assign nxt      = lo_idx(rest);
  assign xs       = {{(AW-W){x_q[W-1]}}, x_q};
  assign fsum     = acc + (xs <<< G);
  assign facc     = fsum >>> (nxt - cur);
  assign fres     = facc >>> G;
  assign isum     = (acc <<< (prev - cur)) + xs;
  assign ifin     = isum <<< cur;
  assign ifin_ovf = (ifin != {{(AW-W){ifin[W-1]}}, ifin[W-1:0]});
  assign acc_nxt  = mode_q ? isum : facc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_q <= 1'b0;
      x_q    <= '0;
      rem    <= '0;
      prev   <= '0;
      acc    <= '0;
      done   <= 1'b0;
      result <= '0;
      ovf    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          x_q    <= x_in;
          mode_q <= int_mode;
          acc    <= '0;
          prev   <= IW'(W - 1);
          rem    <= m_eff;
          if (m_eff == '0) begin
            done   <= 1'b1;
            result <= '0;
            ovf    <= 1'b0;
          end else begin
            busy <= 1'b1;
          end
        end
      end else begin
        acc  <= acc_nxt;
        prev <= cur;
        rem  <= rest;
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= mode_q ? ifin[W-1:0] : fres[W-1:0];
          ovf    <= mode_q & ifin_ovf;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_ONE_BIT_PER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $countones(rem) == $countones($past(rem)) - 1)); // R2
  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && m_eff == '0) |=> (done && result == '0 && !ovf)); // R3
  AST_FRAC_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> !ovf); // R8
  AST_FRAC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q && !x_q[W-1]) |-> (!result[W-1] && result <= W'(x_q))); // R5
  AST_BUSY_HOLDS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> ($stable(x_q) && $stable(mode_q))); // R9
endmodule

// File: tb/horner_mul_tb.sv
module horner_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        int_mode = 1'b0;
  logic [15:0] x_in = '0;
  logic [15:0] m_in = '0;
  logic        done;
  logic [15:0] result;
  logic        ovf;
  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;

  horner_mul dut_i (.clk(clk), .rst_n(rst_n), .start(start), .int_mode(int_mode),
                    .x_in(x_in), .m_in(m_in), .done(done), .result(result), .ovf(ovf));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog R2: actual=%0d cycles expected=<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint frac_ref(input longint x, input logic [15:0] m);
    longint a = 0;
    logic [15:0] mm = m & 16'h7FFF;
    for (int k = 0; k < 15; k++) begin
      if (mm[k]) begin
        int nx = 15;
        for (int j = 14; j > k; j--) if (mm[j]) nx = j;
        a = (a + x * 4) >>> (nx - k);
      end
    end
    return a >>> 2;
  endfunction

  task automatic run(input int x, input logic [15:0] m, input bit im, input bit poke);
    logic [15:0] eff = im ? m : (m & 16'h7FFF);
    int n;
    longint prod, r, rexp;
    logic [15:0] res_s;
    logic ovf_s;
    @(negedge clk);
    start = 1'b1; int_mode = im; x_in = x[15:0]; m_in = m;
    @(negedge clk);
    n = 1;
    while (!done && n < 40) begin
      start = poke; x_in = ~x[15:0]; m_in = ~m; int_mode = ~im;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == $countones(eff) + 1, "R2 latency", n, $countones(eff) + 1);
    res_s = result; ovf_s = ovf;
    if (im) begin
      prod = longint'(x) * longint'(m);
      chk(result == prod[15:0], "R7 int result", result, prod[15:0]);
      chk(ovf == (prod > 32767 || prod < -32768), "R8 int ovf", ovf, (prod > 32767 || prod < -32768));
    end else begin
      rexp = frac_ref(x, m);
      r = longint'($signed(result));
      prod = longint'(x) * longint'(eff);
      chk(result == rexp[15:0], "R4 frac result", r, rexp);
      chk(r * 32768 <= prod && prod - r * 32768 < 49152, "R5 frac accuracy", r * 32768, prod);
      chk(!ovf, "R8 frac ovf", ovf, 0);
    end
    @(negedge clk);
    chk(!done, "R2 done pulse", done, 0);
    if (poke) begin
      @(negedge clk);
      chk(result == res_s && ovf == ovf_s, "R9 hold", result, res_s);
    end
  endtask

  function automatic int xval(input int j);
    case (j)
      0: return -32768; 1: return -1; 2: return 0; 3: return 1; 4: return 32767;
      5: return 8087; 6: return -12345; 7: return 21000; 8: return -300;
      default: return 1234;
    endcase
  endfunction

  initial begin
    #20;
    chk(!done && !ovf && result == 16'h0, "R1 reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && result == 16'h0, "R1 after release", result, 0);

    run(8087, 16'h115E, 1'b0, 1'b0);                        // R4 worked example
    chk(result == 16'd1097 || result == 16'd1096, "R5 example", result, 1097);
    run(23, 16'd77, 1'b1, 1'b0);                            // R7
    chk(result == 16'd1771, "R7 example", result, 1771);
    run(-5, 16'h0000, 1'b0, 1'b0);                          // R3
    chk(result == 16'h0 && !ovf, "R3 zero", result, 0);
    run(12000, 16'h8000, 1'b0, 1'b0);                       // R6 top bit alone
    chk(result == 16'h0, "R6 top bit ignored", result, 0);
    run(12000, 16'h8001, 1'b0, 1'b1);                       // R6 R9
    chk(result == frac_ref(12000, 16'h0001), "R6 top bit no effect", result, frac_ref(12000, 16'h0001));
    run(1, 16'h8000, 1'b1, 1'b0);                           // R8 overflow edge
    chk(ovf == 1'b1, "R8 edge ovf", ovf, 1);
    run(-1, 16'h8000, 1'b1, 1'b0);                          // R8 in range edge
    chk(ovf == 1'b0 && result == 16'h8000, "R8 edge fit", result, 16'h8000);

    for (int b = 0; b < 16; b++) begin
      run(32767, 16'(1) << b, 1'b0, 1'b0);
      run(-32768, 16'(1) << b, 1'b1, 1'b0);
    end
    for (int i = 0; i < 200; i++) begin
      logic [15:0] m = 16'((i * 40503 + i * i * 7) & 16'hFFFF);
      for (int j = 0; j < 10; j++) begin
        run(xval(j), m, 1'b0, (i % 9) == 0);
        run(xval(j), m, 1'b1, (i % 11) == 0);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule